// File: doc/BRIEF.md
# Strobe-Qualified Host Bridge to Dual-Port RAM

This block lets an external host with no clock read and write a word-wide RAM inside the chip. The host drives an active-low chip select, separate active-low write and read strobes, a word address, active-low byte-lane enables and a data bus. The bus is split into input, output and output-enable at the pad boundary. A two-flop synchronizer brings the select and the strobes into the system clock domain. A small sequencer then latches the access fields, commits writes with byte-lane merging or fetches read data into a holding register, and waits for the strobe to end before it accepts the next access.

The output enable is built from the raw select and read-strobe levels, with no synchronizer in the path. The bus is therefore released as soon as the read ends, without waiting for a clock edge. Read data is valid a bounded number of clock edges after the strobe asserts and stays stable until the strobe ends.

Top module: `strobe_ram_bridge`

## Requirements
- R1: After reset the output enable is low and the read-data output is zero.
- R2: The output enable is high exactly while chip select and read strobe are low and write strobe is high, and it falls without waiting for a clock edge when the read strobe rises.
- R3: A write (chip select and write strobe low, read strobe high) is committed to the RAM word at the address by the fourth rising edge after the strobe asserts.
- R4: On a write, byte lane i (data bits 8i+7 down to 8i) of the word is updated only when enable bit i is low; lanes whose enable bit is high keep their old contents, and an all-ones enable leaves the word unchanged.
- R5: On a read, the read-data output carries the addressed word from the fifth rising edge after the strobe asserts until the strobe ends.
- R6: When the write and read strobes are seen active together, no write and no read is performed.
- R7: A strobe that asserts while chip select stays high starts no access.
- R8: Address, enables and write data are latched on the third rising edge after the strobe asserts, and changes to them later in the same strobe have no effect.
- R9: A new access that starts one clock period after the previous strobe ends is accepted and carried out normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostCsN | input | 1 | Host chip select, active low |
| hostWrN | input | 1 | Host write strobe, active low |
| hostRdN | input | 1 | Host read strobe, active low |
| hostAddr | input | ADDR_W | Word address |
| hostBeN | input | DATA_W/8 | Byte-lane enables, active low |
| hostDataIn | input | DATA_W | Write data from the pad |
| hostDataOut | output | DATA_W | Read data to the pad |
| hostDataOe | output | 1 | Pad output enable, high drives the bus |

## Verification
The bench drives every host input on the falling clock edge and counts rising edges from the one that follows. A write is complete after four edges. Read data is due at the fifth edge, and the bench samples it one time unit later. Bus release is combinational, so it is checked one time unit after the read strobe rises, with no edge between. The ignore cases (both strobes, missing select, late field changes) are checked by reading the affected word back through a normal read access.

// File: rtl/srb_pkg.sv
package srb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_COMMIT,
    ST_RD_FETCH,
    ST_RD_LOAD,
    ST_WAIT_END
  } seqState_t;

  typedef struct packed {
    logic capture;
    logic commit;
    logic fetch;
    logic load;
  } bridgeCmd_t;

endpackage

// File: rtl/srb_ctrl.sv
module srb_ctrl
  import srb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostCsN,
  input  logic       hostWrN,
  input  logic       hostRdN,
  output bridgeCmd_t cmd
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] csPipe, wrPipe, rdPipe;
  logic syncCs, syncWr, syncRd;
  seqState_t state, stateNext;
  logic startAccess;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPipe <= '0;
      wrPipe <= '0;
      rdPipe <= '0;
    end else begin
      csPipe <= {csPipe[LAST-1:0], ~hostCsN};
      wrPipe <= {wrPipe[LAST-1:0], ~hostWrN};
      rdPipe <= {rdPipe[LAST-1:0], ~hostRdN};
    end
  end

  assign syncCs = csPipe[LAST];
  assign syncWr = wrPipe[LAST];
  assign syncRd = rdPipe[LAST];

  assign startAccess = (state == ST_IDLE) && syncCs && (syncWr ^ syncRd);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (startAccess)
          stateNext = syncWr ? ST_WR_COMMIT : ST_RD_FETCH;
        else if (syncWr || syncRd)
          stateNext = ST_WAIT_END;
      end
      ST_WR_COMMIT: stateNext = ST_WAIT_END;
      ST_RD_FETCH:  stateNext = ST_RD_LOAD;
      ST_RD_LOAD:   stateNext = ST_WAIT_END;
      ST_WAIT_END:  if (!syncWr && !syncRd) stateNext = ST_IDLE;
      default:      stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    cmd.capture = startAccess;
    cmd.commit  = (state == ST_WR_COMMIT);
    cmd.fetch   = (state == ST_RD_FETCH);
    cmd.load    = (state == ST_RD_LOAD);
  end

  // R6: with both strobes active the sequencer never starts an access
  a_r6_both_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && syncWr && syncRd) |=> (state == ST_WAIT_END));

  // R7: no chip select means the sequencer stays out of the access states
  a_r7_needs_select: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !syncCs) |=> (state == ST_IDLE || state == ST_WAIT_END));

  // R3: a write commit always follows a write capture by one cycle
  a_r3_commit_follows: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WR_COMMIT) |-> ($past(state) == ST_IDLE));

endmodule

// File: rtl/srb_datapath.sv
module srb_datapath
  import srb_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  bridgeCmd_t        cmd,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W/8-1:0] hostBeN,
  input  logic [DATA_W-1:0] hostDataIn,
  output logic [DATA_W-1:0] rdHold
);

  localparam int LANES = DATA_W / 8;
  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] addrQ;
  logic [LANES-1:0]  beQ;
  logic [DATA_W-1:0] dataQ;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] ramQ;
  logic [DATA_W-1:0] mergedWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      beQ   <= '1;
      dataQ <= '0;
    end else if (cmd.capture) begin
      addrQ <= hostAddr;
      beQ   <= hostBeN;
      dataQ <= hostDataIn;
    end
  end

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    assign mergedWord[lane*8 +: 8] = beQ[lane] ? mem[addrQ][lane*8 +: 8]
                                               : dataQ[lane*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (cmd.commit) mem[addrQ] <= mergedWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ramQ   <= '0;
      rdHold <= '0;
    end else begin
      if (cmd.fetch) ramQ   <= mem[addrQ];
      if (cmd.load)  rdHold <= ramQ;
    end
  end

  // R5: the holding register takes the fetched word on load
  a_r5_load_from_ram: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |=> (rdHold == $past(ramQ)));

  // R4: a commit with every lane disabled leaves the word untouched
  a_r4_no_lane_no_change: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.commit && (&beQ)) |=> $stable(mem[addrQ]));

  // R8: latched fields hold still outside the capture cycle
  a_r8_fields_held: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(cmd.capture)) |-> ($stable(addrQ) && $stable(dataQ)));

endmodule

// File: rtl/strobe_ram_bridge.sv
module strobe_ram_bridge
  import srb_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                hostCsN,
  input  logic                hostWrN,
  input  logic                hostRdN,
  input  logic [ADDR_W-1:0]   hostAddr,
  input  logic [DATA_W/8-1:0] hostBeN,
  input  logic [DATA_W-1:0]   hostDataIn,
  output logic [DATA_W-1:0]   hostDataOut,
  output logic                hostDataOe
);

  bridgeCmd_t cmd;

  srb_ctrl #(.SYNC_STAGES(2)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .hostCsN (hostCsN),
    .hostWrN (hostWrN),
    .hostRdN (hostRdN),
    .cmd     (cmd)
  );

  srb_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .hostAddr   (hostAddr),
    .hostBeN    (hostBeN),
    .hostDataIn (hostDataIn),
    .rdHold     (hostDataOut)
  );

  // Unsynchronized levels so the bus is released with no clock latency
  assign hostDataOe = !hostCsN && !hostRdN && hostWrN;

  // R2: output enable never drives while a write strobe is low
  always_comb begin
    a_r2_no_drive_on_write: assert (!(hostDataOe && !hostWrN));
  end

endmodule

// File: tb/strobe_ram_bridge_tb.sv
module strobe_ram_bridge_tb;

  localparam int AW = 6;
  localparam int DW = 32;
  localparam int BL = DW / 8;

  typedef struct packed {
    logic          isWrite;
    logic [AW-1:0] addr;
    logic [BL-1:0] beN;
    logic [DW-1:0] data;
    logic [DW-1:0] expect_;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 6'd5,  4'b0000, 32'h11223344, 32'h0},
    '{1'b0, 6'd5,  4'b0000, 32'h0,        32'h11223344},
    '{1'b1, 6'd5,  4'b1010, 32'hAABBCCDD, 32'h0},
    '{1'b0, 6'd5,  4'b0000, 32'h0,        32'h11BB33DD},
    '{1'b1, 6'd63, 4'b0000, 32'hDEADBEEF, 32'h0},
    '{1'b1, 6'd0,  4'b0000, 32'h01020304, 32'h0},
    '{1'b1, 6'd0,  4'b0111, 32'hFFEEDDCC, 32'h0},
    '{1'b0, 6'd0,  4'b0000, 32'h0,        32'hFF020304},
    '{1'b0, 6'd63, 4'b0000, 32'h0,        32'hDEADBEEF},
    '{1'b1, 6'd63, 4'b1111, 32'h00000000, 32'h0},
    '{1'b0, 6'd63, 4'b0000, 32'h0,        32'hDEADBEEF}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, wrN = 1'b1, rdN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [BL-1:0] beN = '1;
  logic [DW-1:0] dIn = '0;
  logic [DW-1:0] dOut;
  logic oe;
  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  strobe_ram_bridge #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .hostCsN(csN), .hostWrN(wrN), .hostRdN(rdN),
    .hostAddr(addr), .hostBeN(beN), .hostDataIn(dIn),
    .hostDataOut(dOut), .hostDataOe(oe)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // Write: strobe low over several edges, fields scrambled after the latch edge
  task automatic doWrite(input logic [AW-1:0] a, input logic [BL-1:0] b,
                         input logic [DW-1:0] d, input int gap);
    csN = 1'b0; wrN = 1'b0; addr = a; beN = b; dIn = d;
    edges(3);
    dIn = ~d; beN = '0; addr = a + 1'b1;
    edges(2);
    wrN = 1'b1; csN = 1'b1;
    edges(gap);
  endtask

  task automatic doRead(input logic [AW-1:0] a, input logic [DW-1:0] exp,
                        input string req, input int gap);
    csN = 1'b0; rdN = 1'b0; addr = a;
    repeat (5) @(posedge clk);
    #1;
    check(req, dOut, exp);
    check("R2 oe during read", {31'b0, oe}, 32'd1);
    @(negedge clk);
    rdN = 1'b1;
    #1;
    check("R2 release", {31'b0, oe}, 32'd0);
    csN = 1'b1;
    @(negedge clk);
    edges(gap);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
      end
    end
  end

  initial begin
    edges(2);
    // R1: reset state
    check("R1 oe", {31'b0, oe}, 32'd0);
    check("R1 data", dOut, 32'd0);
    rstN = 1'b1;
    edges(2);

    // R3 R4 R5 R8: vector table
    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].isWrite)
        doWrite(VECS[i].addr, VECS[i].beN, VECS[i].data, 3);
      else
        doRead(VECS[i].addr, VECS[i].expect_, "R3/R4/R5/R8 table read", 3);
    end

    // R6: both strobes together are ignored
    csN = 1'b0; wrN = 1'b0; rdN = 1'b0; addr = 6'd0; beN = '0; dIn = 32'h0;
    edges(6);
    check("R6 oe while both low", {31'b0, oe}, 32'd0);
    wrN = 1'b1; rdN = 1'b1; csN = 1'b1;
    edges(3);
    doRead(6'd0, 32'hFF020304, "R6 word unchanged", 3);

    // R7: write strobe with no chip select
    wrN = 1'b0; addr = 6'd0; beN = '0; dIn = 32'h5555AAAA;
    edges(6);
    wrN = 1'b1;
    edges(3);
    doRead(6'd0, 32'hFF020304, "R7 word unchanged", 3);

    // R9: one-cycle gap between accesses
    doWrite(6'd10, 4'b0000, 32'h89ABCDEF, 1);
    doWrite(6'd11, 4'b0000, 32'h13579BDF, 1);
    doRead(6'd10, 32'h89ABCDEF, "R9 first after gap", 1);
    doRead(6'd11, 32'h13579BDF, "R9 second after gap", 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule